// File: doc/BRIEF.md
# Trace Line Builder

This block assembles trace lines for a trace cache. Instructions arrive one per cycle, in program order along the path that was actually followed. Each one comes with its address, its encoding, a flag that marks a conditional branch, that branch's resolved direction and its taken target. The block appends each instruction to a staging line. Because it follows the path that was executed, one line can join several basic blocks from unrelated code regions.

The line closes as soon as either of two limits is reached: the maximum number of instructions, or the maximum number of conditional branches. While the line is built, the block records the direction of each conditional branch in order, and the address of the first instruction as the line's tag. When the line closes, it also records the two addresses that can follow it.

A closed line is offered on a write port with a valid/ready handshake. While it waits there, new input is stalled. A flush input throws away a line that is only partly built.

Top module: `trace_fill_buffer`

## Requirements
- R1: After reset no line is offered (`line_valid_o` low) and the input is ready (`in_ready_o` high).
- R2: The address of the first instruction accepted into an empty buffer is the tag of the line (`line_tag_o`).
- R3: Accepted instructions fill the line in arrival order. The k-th one is placed at bits `[k*INSN_W +: INSN_W]` of `line_insns_o`, and `line_count_o` reports how many there are. Instructions whose addresses are not adjacent go into the same line.
- R4: A line closes when it holds `MAX_INSNS` (16) instructions.
- R5: A line closes when it takes in its `MAX_BRS`-th (3rd) conditional branch, and that branch is the last instruction of the line.
- R6: Bit i of `line_path_o` is the direction of the i-th conditional branch in the line (1 = taken). Bits at and above `line_br_count_o` read 0, and `line_br_count_o` gives the number of conditional branches in the line.
- R7: If the instruction that closes the line is a conditional branch, `line_taken_next_o` is its target and `line_fall_next_o` is its address plus `INSN_BYTES` (4).
- R8: If the instruction that closes the line is not a conditional branch, both successor outputs equal its address plus `INSN_BYTES`.
- R9: While a line is offered, `in_ready_o` is low, input is ignored, and every line output stays unchanged until `line_ready_i` is seen high.
- R10: In the cycle after a handshake (valid and ready both high), no line is offered and input is ready again. The next accepted instruction starts a new line.
- R11: `flush_i` throws away a line that is partly built. An instruction presented in the same cycle as the flush is dropped.
- R12: A flush while a closed line is offered does not remove that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Throw away the partly built line |
| in_valid_i | input | 1 | Instruction presented |
| in_ready_o | output | 1 | Block can accept an instruction |
| in_pc_i | input | ADDR_W | Instruction address |
| in_insn_i | input | INSN_W | Instruction encoding |
| in_is_cbr_i | input | 1 | Instruction is a conditional branch |
| in_taken_i | input | 1 | Resolved direction of that branch (1 = taken) |
| in_target_i | input | ADDR_W | Taken target of that branch |
| line_valid_o | output | 1 | A closed line is offered |
| line_ready_i | input | 1 | Trace cache takes the line |
| line_tag_o | output | ADDR_W | Address of the first instruction |
| line_insns_o | output | MAX_INSNS*INSN_W | Instruction slots, slot 0 in the low bits |
| line_count_o | output | $clog2(MAX_INSNS+1) | Number of valid slots |
| line_path_o | output | MAX_BRS | Branch directions, first branch in bit 0 |
| line_br_count_o | output | $clog2(MAX_BRS+1) | Number of conditional branches |
| line_taken_next_o | output | ADDR_W | Successor if the final branch is taken |
| line_fall_next_o | output | ADDR_W | Sequential successor |

## Verification
The bench builds the block with its defaults: 32-bit addresses and encodings, 16 instruction slots, 3 branches per line and 4-byte instructions. With these values both closing limits can be reached in a short run. It checks the branch-count limit in lines of three to six instructions, with taken and not-taken branches mixed. It checks the size limit with a full sixteen-slot line of straight code, and with a line whose sixteenth instruction is only its second branch, which separates the two successor rules.

// File: rtl/tfb_pkg.sv
package tfb_pkg;

    // Why the current instruction ended the line (if it did)
    typedef enum logic [1:0] {
        CLOSE_NONE   = 2'd0,
        CLOSE_SIZE   = 2'd1,
        CLOSE_BRANCH = 2'd2
    } close_e;

endpackage

// File: rtl/tfb_close_logic.sv
module tfb_close_logic
    import tfb_pkg::*;
#(
    parameter int MAX_INSNS = 16,
    parameter int MAX_BRS   = 3,
    parameter int CNT_W     = $clog2(MAX_INSNS + 1),
    parameter int BR_W      = $clog2(MAX_BRS + 1)
) (
    input  logic             accept,
    input  logic             is_cbr,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [BR_W-1:0]  br_q,
    output close_e           reason
);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(MAX_INSNS - 1);
    localparam logic [BR_W-1:0]  LAST_BR   = BR_W'(MAX_BRS - 1);

    always_comb begin
        reason = CLOSE_NONE;
        if (accept) begin
            if (is_cbr && (br_q == LAST_BR)) begin
                reason = CLOSE_BRANCH;
            end else if (cnt_q == LAST_SLOT) begin
                reason = CLOSE_SIZE;
            end
        end
    end

endmodule

// File: rtl/tfb_path_rec.sv
module tfb_path_rec #(
    parameter int MAX_BRS = 3,
    parameter int BR_W    = $clog2(MAX_BRS + 1)
) (
    input  logic               clear,
    input  logic               rec_en,
    input  logic               taken,
    input  logic [BR_W-1:0]    br_q,
    input  logic [MAX_BRS-1:0] path_q,
    output logic [MAX_BRS-1:0] path_d
);
    // One bit of direction history for each branch position
    for (genvar i = 0; i < MAX_BRS; i++) begin : g_bit
        always_comb begin
            if (clear) begin
                path_d[i] = 1'b0;
            end else if (rec_en && (br_q == BR_W'(i))) begin
                path_d[i] = taken;
            end else begin
                path_d[i] = path_q[i];
            end
        end
    end

endmodule

// File: rtl/tfb_slot_store.sv
module tfb_slot_store #(
    parameter int MAX_INSNS = 16,
    parameter int INSN_W    = 32,
    parameter int IDX_W     = $clog2(MAX_INSNS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [INSN_W-1:0]           wr_data,
    output logic [MAX_INSNS*INSN_W-1:0] slots_flat
);
    for (genvar s = 0; s < MAX_INSNS; s++) begin : g_slot
        logic [INSN_W-1:0] slot_d;
        logic [INSN_W-1:0] slot_q;

        always_comb begin
            slot_d = slot_q;
            if (wr_en && (wr_idx == IDX_W'(s))) begin
                slot_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign slots_flat[s*INSN_W +: INSN_W] = slot_q;
    end

endmodule

// File: rtl/trace_fill_buffer.sv
module trace_fill_buffer
    import tfb_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_W     = 32,
    parameter int MAX_INSNS  = 16,
    parameter int MAX_BRS    = 3,
    parameter int INSN_BYTES = 4,
    localparam int CNT_W     = $clog2(MAX_INSNS + 1),
    localparam int BR_W      = $clog2(MAX_BRS + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush_i,
    input  logic                        in_valid_i,
    output logic                        in_ready_o,
    input  logic [ADDR_W-1:0]           in_pc_i,
    input  logic [INSN_W-1:0]           in_insn_i,
    input  logic                        in_is_cbr_i,
    input  logic                        in_taken_i,
    input  logic [ADDR_W-1:0]           in_target_i,
    output logic                        line_valid_o,
    input  logic                        line_ready_i,
    output logic [ADDR_W-1:0]           line_tag_o,
    output logic [MAX_INSNS*INSN_W-1:0] line_insns_o,
    output logic [CNT_W-1:0]            line_count_o,
    output logic [MAX_BRS-1:0]          line_path_o,
    output logic [BR_W-1:0]             line_br_count_o,
    output logic [ADDR_W-1:0]           line_taken_next_o,
    output logic [ADDR_W-1:0]           line_fall_next_o
);

    typedef struct packed {
        logic               hold;
        logic [CNT_W-1:0]   cnt;
        logic [BR_W-1:0]    br;
        logic [MAX_BRS-1:0] path;
        logic [ADDR_W-1:0]  tag;
        logic [ADDR_W-1:0]  tnext;
        logic [ADDR_W-1:0]  fnext;
    } fill_state_t;

    fill_state_t st_d;
    fill_state_t st_q;

    logic               accept;
    logic               path_clear;
    logic [ADDR_W-1:0]  seq_pc;
    logic [MAX_BRS-1:0] path_next;
    close_e             close_why;

    assign accept     = in_valid_i && !st_q.hold && !flush_i;
    assign seq_pc     = in_pc_i + ADDR_W'(INSN_BYTES);
    assign path_clear = st_q.hold ? line_ready_i : flush_i;

    tfb_close_logic #(
        .MAX_INSNS (MAX_INSNS),
        .MAX_BRS   (MAX_BRS),
        .CNT_W     (CNT_W),
        .BR_W      (BR_W)
    ) u_close (
        .accept (accept),
        .is_cbr (in_is_cbr_i),
        .cnt_q  (st_q.cnt),
        .br_q   (st_q.br),
        .reason (close_why)
    );

    tfb_path_rec #(
        .MAX_BRS (MAX_BRS),
        .BR_W    (BR_W)
    ) u_path (
        .clear  (path_clear),
        .rec_en (accept && in_is_cbr_i),
        .taken  (in_taken_i),
        .br_q   (st_q.br),
        .path_q (st_q.path),
        .path_d (path_next)
    );

    tfb_slot_store #(
        .MAX_INSNS (MAX_INSNS),
        .INSN_W    (INSN_W),
        .IDX_W     (CNT_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (accept),
        .wr_idx     (st_q.cnt),
        .wr_data    (in_insn_i),
        .slots_flat (line_insns_o)
    );

    always_comb begin
        st_d      = st_q;
        st_d.path = path_next;
        if (st_q.hold) begin
            if (line_ready_i) begin
                st_d.hold = 1'b0;
                st_d.cnt  = '0;
                st_d.br   = '0;
            end
        end else if (flush_i) begin
            st_d.cnt = '0;
            st_d.br  = '0;
        end else if (accept) begin
            if (st_q.cnt == '0) begin
                st_d.tag = in_pc_i;
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (in_is_cbr_i) begin
                st_d.br = st_q.br + BR_W'(1);
            end
            if (close_why != CLOSE_NONE) begin
                st_d.hold  = 1'b1;
                st_d.fnext = seq_pc;
                st_d.tnext = in_is_cbr_i ? in_target_i : seq_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready_o        = !st_q.hold;
    assign line_valid_o      = st_q.hold;
    assign line_tag_o        = st_q.tag;
    assign line_count_o      = st_q.cnt;
    assign line_path_o       = st_q.path;
    assign line_br_count_o   = st_q.br;
    assign line_taken_next_o = st_q.tnext;
    assign line_fall_next_o  = st_q.fnext;

endmodule

// File: rtl/tfb_chk.sv
module tfb_chk #(
    parameter int ADDR_W    = 32,
    parameter int MAX_INSNS = 16,
    parameter int MAX_BRS   = 3,
    parameter int CNT_W     = $clog2(MAX_INSNS + 1),
    parameter int BR_W      = $clog2(MAX_BRS + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               flush_i,
    input logic               in_ready_o,
    input logic               line_valid_o,
    input logic               line_ready_i,
    input logic [ADDR_W-1:0]  line_tag_o,
    input logic [CNT_W-1:0]   line_count_o,
    input logic [MAX_BRS-1:0] line_path_o,
    input logic [BR_W-1:0]    line_br_count_o,
    input logic [ADDR_W-1:0]  line_taken_next_o,
    input logic [ADDR_W-1:0]  line_fall_next_o
);

    // R9
    held_line_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid_o && !line_ready_i) |=> (line_valid_o && $stable(line_tag_o)
            && $stable(line_count_o) && $stable(line_path_o)
            && $stable(line_taken_next_o) && $stable(line_fall_next_o)));

    // R4 R5
    close_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_valid_o) |-> ((line_count_o == CNT_W'(MAX_INSNS))
            || (line_br_count_o == BR_W'(MAX_BRS))));

    // R4 R5
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_count_o <= CNT_W'(MAX_INSNS)) && (line_br_count_o <= BR_W'(MAX_BRS)));

    // R6
    path_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid_o |-> ((line_path_o >> line_br_count_o) == '0));

    // R10
    handshake_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid_o && line_ready_i) |=> (!line_valid_o && in_ready_o));

    // R12
    flush_keeps_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_valid_o && flush_i && !line_ready_i) |=> line_valid_o);

endmodule

bind trace_fill_buffer tfb_chk #(
    .ADDR_W    (ADDR_W),
    .MAX_INSNS (MAX_INSNS),
    .MAX_BRS   (MAX_BRS)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .flush_i           (flush_i),
    .in_ready_o        (in_ready_o),
    .line_valid_o      (line_valid_o),
    .line_ready_i      (line_ready_i),
    .line_tag_o        (line_tag_o),
    .line_count_o      (line_count_o),
    .line_path_o       (line_path_o),
    .line_br_count_o   (line_br_count_o),
    .line_taken_next_o (line_taken_next_o),
    .line_fall_next_o  (line_fall_next_o)
);

// File: tb/trace_fill_buffer_tb.sv
module trace_fill_buffer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 16;
    localparam int NB = 3;

    typedef struct packed {
        logic [31:0] pc;
        logic        cbr;
        logic        tk;
        logic [31:0] tgt;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        // line A: three branches, non-adjacent regions
        '{32'h0000_1000, 1'b0, 1'b0, 32'h0},
        '{32'h0000_1004, 1'b1, 1'b0, 32'h0000_2000},
        '{32'h0000_1008, 1'b0, 1'b0, 32'h0},
        '{32'h0000_100C, 1'b1, 1'b1, 32'h0000_3000},
        '{32'h0000_3000, 1'b0, 1'b0, 32'h0},
        '{32'h0000_3004, 1'b1, 1'b1, 32'h0000_4000},
        // line B: a jump merged in, then three branches
        '{32'h0000_4000, 1'b0, 1'b0, 32'h0},
        '{32'h0000_4004, 1'b0, 1'b0, 32'h0},
        '{32'h0000_8000, 1'b0, 1'b0, 32'h0},
        '{32'h0000_8004, 1'b1, 1'b1, 32'h0000_9000},
        '{32'h0000_9000, 1'b1, 1'b0, 32'h0000_A000},
        '{32'h0000_9004, 1'b1, 1'b0, 32'h0000_B000},
        // line C: branches only
        '{32'h0000_5000, 1'b1, 1'b1, 32'h0000_6000},
        '{32'h0000_6000, 1'b1, 1'b1, 32'h0000_7000},
        '{32'h0000_7000, 1'b1, 1'b1, 32'h0000_7100},
        // partial line, later flushed
        '{32'h0000_7100, 1'b0, 1'b0, 32'h0},
        '{32'h0000_7104, 1'b1, 1'b1, 32'h0000_7200},
        '{32'h0000_7200, 1'b0, 1'b0, 32'h0},
        '{32'h0000_7204, 1'b0, 1'b0, 32'h0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          in_valid_i = 1'b0;
    logic          in_ready_o;
    logic [31:0]   in_pc_i = '0;
    logic [31:0]   in_insn_i = '0;
    logic          in_is_cbr_i = 1'b0;
    logic          in_taken_i = 1'b0;
    logic [31:0]   in_target_i = '0;
    logic          line_valid_o;
    logic          line_ready_i = 1'b0;
    logic [31:0]   line_tag_o;
    logic [NI*32-1:0] line_insns_o;
    logic [4:0]    line_count_o;
    logic [2:0]    line_path_o;
    logic [1:0]    line_br_count_o;
    logic [31:0]   line_taken_next_o;
    logic [31:0]   line_fall_next_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int          m_cnt = 0;
    int          m_br = 0;
    logic [2:0]  m_path = '0;
    logic [31:0] m_tag = '0;
    logic [31:0] m_tn = '0;
    logic [31:0] m_fn = '0;
    logic [31:0] m_insn [NI];
    bit          m_closed = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trace_fill_buffer u_dut (
        .clk (clk), .rst_n (rst_n), .flush_i (flush_i),
        .in_valid_i (in_valid_i), .in_ready_o (in_ready_o),
        .in_pc_i (in_pc_i), .in_insn_i (in_insn_i),
        .in_is_cbr_i (in_is_cbr_i), .in_taken_i (in_taken_i),
        .in_target_i (in_target_i),
        .line_valid_o (line_valid_o), .line_ready_i (line_ready_i),
        .line_tag_o (line_tag_o), .line_insns_o (line_insns_o),
        .line_count_o (line_count_o), .line_path_o (line_path_o),
        .line_br_count_o (line_br_count_o),
        .line_taken_next_o (line_taken_next_o),
        .line_fall_next_o (line_fall_next_o)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [31:0] pc);
        return {16'hA5C3, pc[15:0]};
    endfunction

    task automatic model_clear();
        m_cnt = 0; m_br = 0; m_path = '0; m_closed = 1'b0;
    endtask

    // Compare the offered line with the model, stall with junk, then take it.
    task automatic verify_line(input bit flush_mid);
        chk(line_valid_o == 1'b1, "R4/R5 line offered", 64'(line_valid_o), 64'd1);
        chk(in_ready_o == 1'b0, "R9 input stalled", 64'(in_ready_o), 64'd0);
        chk(line_tag_o == m_tag, "R2 tag", 64'(line_tag_o), 64'(m_tag));
        chk(int'(line_count_o) == m_cnt, "R3 count", 64'(line_count_o), 64'(m_cnt));
        chk(int'(line_br_count_o) == m_br, "R6 branch count", 64'(line_br_count_o), 64'(m_br));
        chk(line_path_o == m_path, "R6 path", 64'(line_path_o), 64'(m_path));
        chk(line_taken_next_o == m_tn, "R7/R8 taken successor", 64'(line_taken_next_o), 64'(m_tn));
        chk(line_fall_next_o == m_fn, "R7/R8 fall successor", 64'(line_fall_next_o), 64'(m_fn));
        for (int k = 0; k < m_cnt; k++) begin
            chk(line_insns_o[k*32 +: 32] == m_insn[k], "R3 slot",
                64'(line_insns_o[k*32 +: 32]), 64'(m_insn[k]));
        end
        // junk input while offered (R9), optional flush (R12)
        in_valid_i = 1'b1; in_pc_i = 32'hDEAD_0000; in_insn_i = 32'hDEAD_BEEF;
        in_is_cbr_i = 1'b1; in_taken_i = 1'b1; in_target_i = 32'hDEAD_1000;
        for (int c = 0; c < 3; c++) begin
            flush_i = flush_mid && (c == 1);
            @(negedge clk);
            chk(line_valid_o == 1'b1, flush_mid ? "R12 line kept" : "R9 line held",
                64'(line_valid_o), 64'd1);
            chk(line_tag_o == m_tag && int'(line_count_o) == m_cnt && line_path_o == m_path,
                "R9 outputs stable", 64'(line_tag_o), 64'(m_tag));
        end
        flush_i = 1'b0;
        line_ready_i = 1'b1;
        @(negedge clk);
        line_ready_i = 1'b0; in_valid_i = 1'b0; in_is_cbr_i = 1'b0; in_taken_i = 1'b0;
        chk(line_valid_o == 1'b0 && in_ready_o == 1'b1, "R10 released",
            64'({line_valid_o, in_ready_o}), 64'b01);
        model_clear();
    endtask

    // Present one instruction for one cycle (called at a negedge).
    task automatic push(input logic [31:0] pc, input logic cbr,
                        input logic tk, input logic [31:0] tgt);
        in_valid_i = 1'b1; in_pc_i = pc; in_insn_i = enc(pc);
        in_is_cbr_i = cbr; in_taken_i = tk; in_target_i = tgt;
        @(negedge clk);
        in_valid_i = 1'b0; in_is_cbr_i = 1'b0; in_taken_i = 1'b0;
        if (m_cnt == 0) m_tag = pc;
        m_insn[m_cnt] = enc(pc);
        m_cnt++;
        if (cbr) begin
            m_path[m_br] = tk;
            m_br++;
        end
        if (m_cnt == NI || (cbr && m_br == NB)) begin
            m_closed = 1'b1;
            m_fn = pc + 32'd4;
            m_tn = cbr ? tgt : pc + 32'd4;
        end
        if (m_closed) verify_line(1'b0);
        else chk(line_valid_o == 1'b0, "R4/R5 not closed early", 64'(line_valid_o), 64'd0);
    endtask

    task automatic flush_pulse(input bit with_input);
        flush_i = 1'b1;
        if (with_input) begin
            in_valid_i = 1'b1; in_pc_i = 32'h0000_F000; in_insn_i = enc(32'h0000_F000);
        end
        @(negedge clk);
        flush_i = 1'b0; in_valid_i = 1'b0;
        model_clear();
        chk(line_valid_o == 1'b0 && in_ready_o == 1'b1, "R11 flush idle",
            64'({line_valid_o, in_ready_o}), 64'b01);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(line_valid_o == 1'b0, "R1 no line in reset", 64'(line_valid_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_valid_o == 1'b0 && in_ready_o == 1'b1, "R1 after reset",
            64'({line_valid_o, in_ready_o}), 64'b01);

        // table walk: R2 R3 R5 R6 R7 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            push(VECS[v].pc, VECS[v].cbr, VECS[v].tk, VECS[v].tgt);
        end

        // R11: drop the partial line, including an input in the flush cycle
        flush_pulse(1'b1);
        push(32'h0000_1100, 1'b1, 1'b0, 32'h0000_1200);
        push(32'h0000_1104, 1'b1, 1'b1, 32'h0000_1300);
        push(32'h0000_1300, 1'b1, 1'b0, 32'h0000_1400);

        // R4 R8: sixteen straight-line instructions
        for (int k = 0; k < NI; k++) begin
            push(32'h0000_C000 + 32'(4*k), 1'b0, 1'b0, 32'h0);
        end

        // R4 R7: sixteenth instruction is the second branch
        for (int k = 0; k < NI - 1; k++) begin
            push(32'h0000_D000 + 32'(4*k), k == 2, 1'b1, 32'h0000_D008);
        end
        push(32'h0000_D03C, 1'b1, 1'b0, 32'h0000_E000);

        // R12: flush while a finished line waits
        push(32'h0000_2100, 1'b1, 1'b1, 32'h0000_2200);
        push(32'h0000_2200, 1'b1, 1'b1, 32'h0000_2300);
        in_valid_i = 1'b1; in_pc_i = 32'h0000_2300; in_insn_i = enc(32'h0000_2300);
        in_is_cbr_i = 1'b1; in_taken_i = 1'b0; in_target_i = 32'h0000_2400;
        @(negedge clk);
        in_valid_i = 1'b0;
        m_insn[m_cnt] = enc(32'h0000_2300);
        m_cnt++; m_path[m_br] = 1'b0; m_br++;
        m_tn = 32'h0000_2400; m_fn = 32'h0000_2304;
        verify_line(1'b1);

        // R10: fresh line after the handshake starts from its own tag
        push(32'h0000_2500, 1'b1, 1'b1, 32'h0000_2600);
        push(32'h0000_2600, 1'b1, 1'b1, 32'h0000_2700);
        push(32'h0000_2700, 1'b1, 1'b1, 32'h0000_2800);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule